// File: doc/BRIEF.md
# SCSI Initiator Command Sequencer

This block sits behind the command register of a SCSI initiator controller. Each command byte it accepts is decoded into an operation and a DMA flag. From these it computes the next status, interrupt-reason, sequence-step and FIFO-flag values, and it raises or keeps the interrupt line. Selection and transfer commands are turned into requests to an external target model. That model states, in the same cycle, how much data the dispatched command will move: a positive count means data flows in, a negative count means data flows out. The model reports the end of each DMA burst with a one-cycle done pulse.

The select-with-attention-and-stop operation does not send the command when the target is selected. It only marks a command as pending, and the next transfer-information command sends it. A target that does not answer is reported as a disconnect rather than as a bus-service event. All command handling takes one clock cycle. The bytes moved by a DMA burst are the smaller of the loaded transfer count and the data the target still has outstanding.

Top module: `scsi_cmd_seq`

## Requirements
- R1: After reset, `status`, `intr_reason`, `seq_step`, `fifo_flags` and `tc_cur` are 0, and `irq`, `dma_mode` and `cmd_pending` are low.
- R2: Any accepted command byte with bit 7 set raises `dma_mode` and loads `tc_cur` with `{tc_mid, tc_lo}`. A byte with bit 7 clear lowers `dma_mode` and leaves `tc_cur` unchanged. `status` bit 7 always mirrors `irq`, and bits 6:0 hold the phase and count bits.
- R3: Flush (low 7 bits 0x01) sets `intr_reason` to 0x08 and sets `seq_step` and `fifo_flags` to 0. It does not touch `irq`.
- R4: Bus reset (0x03) sets `intr_reason` to 0x80. It raises `irq` only while `rst_report_dis` is low.
- R5: Select (0x42) or select-and-stop (0x43) sent to an ID of 8 or more, or to an ID whose `target_present` bit is 0, clears status bits 6:0, sets `intr_reason` to 0x20 and `seq_step` to 0, raises `irq`, and issues no target request.
- R6: Select (0x42) sent to a present target pulses `tgt_cmd_req` in the command cycle. `tgt_cmd_len` is the transfer count capped at 32, where a count of 0 counts as 65536. Status bits 6:0 become 0x11 if `tgt_len` is positive, 0x10 if it is negative, and stay unchanged if it is zero. `intr_reason` becomes 0x18 and `seq_step` 4, and `irq` rises.
- R7: Select-and-stop (0x43) sent to a present target issues no request. It sets `cmd_pending`, sets status bits 6:0 to 0x12, `intr_reason` to 0x18 and `seq_step` to 4, and raises `irq`. A later transfer-information command (0x10) then dispatches the pending command exactly as R6 does, with the length capped at 32, and clears `cmd_pending`.
- R8: Transfer information in DMA mode with no pending command clears status bit 4. If at least one byte is outstanding, the next cycle carries a one-cycle `xfer_req` with `xfer_len` equal to the smaller of the count (0 counts as 65536) and the outstanding magnitude. If nothing is outstanding, no request is made.
- R9: An `xfer_done` pulse sets status bit 4, keeps the direction bits, and sets `intr_reason` to 0x10, `seq_step` to 0, `fifo_flags` to 0 and `tc_cur` to 0. It raises `irq` and removes the burst length from the outstanding data.
- R10: Command-complete (0x11) pulses `resp_req` for one cycle and raises `irq`. In DMA mode it also sets status bits 6:0 to 0x13, `intr_reason` to 0x18 and `seq_step` to 4. Otherwise it sets `fifo_flags` to 2 and leaves status and reason unchanged.
- R11: Message-accepted (0x12) acts as R10 and then forces `intr_reason` to 0x20 and `seq_step` to 0.
- R12: Chip reset (0x02) returns every register to its R1 value and drops `irq`.
- R13: No-op (0x00), set-attention (0x1A), enable-selection (0x44) and every code not listed above leave status bits 6:0, `intr_reason`, `seq_step` and `irq` unchanged.
- R14: `irq_clr` drops `irq` in the next cycle unless a command or `xfer_done` raises it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command byte is written this cycle |
| cmd_byte | input | 8 | Command byte: bit 7 selects DMA, bits 6:0 select the operation |
| tc_lo | input | 8 | Written low byte of the transfer count |
| tc_mid | input | 8 | Written middle byte of the transfer count |
| target_id | input | 4 | Target ID taken from the bus-ID register |
| target_present | input | 8 | One presence flag per target ID |
| rst_report_dis | input | 1 | Suppresses the interrupt on a bus reset |
| irq_clr | input | 1 | Interrupt-reason read; lowers the interrupt |
| tgt_len | input | 18 | Signed data length the target returns for a dispatched command |
| xfer_done | input | 1 | The current DMA burst has finished |
| status | output | 8 | Bit 7 is the interrupt; bits 6:0 hold the phase and terminal-count bits |
| intr_reason | output | 8 | Interrupt reason |
| seq_step | output | 3 | Sequence step |
| fifo_flags | output | 5 | FIFO byte count |
| tc_cur | output | 16 | Current transfer count |
| dma_mode | output | 1 | The last command selected DMA |
| cmd_pending | output | 1 | A stopped selection is waiting for transfer information |
| irq | output | 1 | Interrupt line |
| tgt_cmd_req | output | 1 | Dispatches a command to the target (same cycle) |
| tgt_cmd_sel | output | 4 | Target addressed by the request |
| tgt_cmd_len | output | 6 | Command length, capped at 32 |
| xfer_req | output | 1 | One-cycle DMA burst request |
| xfer_len | output | 17 | Burst length in bytes |
| resp_req | output | 1 | One-cycle request to return the status and message bytes |

## Verification
Each opcode is applied from a clean reset, with the target ID and presence mask set up in several ways: an ID past the last target, a present ID with its flag cleared, and present targets returning positive, negative and zero lengths. These patterns separate the disconnect path from a dispatch, and a data-in result from a data-out or empty one. Longer directed runs chain a stopped selection with a later transfer, then issue bursts in both directions whose count is zero, smaller than the outstanding data or larger than it. This shows which of the two limits sets the burst length and that a finished burst refills the completion status. The same runs cover the DMA flag reload, flags written by a non-DMA response and cleared by a flush, the suppressed bus-reset interrupt, and a chip reset issued in mid-sequence.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_FLUSH,
        OP_CHIPRST,
        OP_BUSRST,
        OP_XFER,
        OP_STATUS,
        OP_MSGOK,
        OP_SEL,
        OP_SELSTOP,
        OP_IGNORE
    } seq_op_e;

    // status bits 6:0
    localparam logic [6:0] ST_TC   = 7'h10;
    localparam logic [6:0] ST_DIN  = 7'h01;
    localparam logic [6:0] ST_CMDP = 7'h02;
    localparam logic [6:0] ST_STSP = 7'h03;

    // interrupt reasons
    localparam logic [7:0] IR_FUNC = 8'h08;
    localparam logic [7:0] IR_SVC  = 8'h10;
    localparam logic [7:0] IR_DISC = 8'h20;
    localparam logic [7:0] IR_BRST = 8'h80;

    localparam logic [2:0] STEP_CMD = 3'd4;

endpackage

// File: rtl/scsi_seq_decode.sv
module scsi_seq_decode
    import scsi_seq_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output logic       dma_sel,
    output seq_op_e    op
);
    assign dma_sel = cmd_byte[7];

    always_comb begin
        case (cmd_byte[6:0])
            7'h00:   op = OP_NOP;
            7'h01:   op = OP_FLUSH;
            7'h02:   op = OP_CHIPRST;
            7'h03:   op = OP_BUSRST;
            7'h10:   op = OP_XFER;
            7'h11:   op = OP_STATUS;
            7'h12:   op = OP_MSGOK;
            7'h42:   op = OP_SEL;
            7'h43:   op = OP_SELSTOP;
            default: op = OP_IGNORE;
        endcase
    end
endmodule

// File: rtl/scsi_seq_len.sv
module scsi_seq_len #(
    parameter int CNT_W = 16,
    parameter int BUF_N = 32,
    parameter int REM_W = CNT_W + 2,
    parameter int LEN_W = $clog2(BUF_N) + 1
) (
    input  logic [CNT_W-1:0]        count_raw,
    input  logic signed [REM_W-1:0] remain,
    output logic [CNT_W:0]          burst_len,
    output logic [LEN_W-1:0]        cmd_len
);
    logic [CNT_W:0]   eff_cnt;
    logic [REM_W-1:0] mag;

    // a zero count stands for the full 2**CNT_W range
    assign eff_cnt = (count_raw == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count_raw};
    assign mag     = remain[REM_W-1] ? REM_W'(-remain) : REM_W'(remain);

    always_comb begin
        if (mag < REM_W'(eff_cnt)) burst_len = mag[CNT_W:0];
        else                       burst_len = eff_cnt;
    end

    always_comb begin
        if (eff_cnt < (CNT_W+1)'(BUF_N)) cmd_len = eff_cnt[LEN_W-1:0];
        else                             cmd_len = LEN_W'(BUF_N);
    end
endmodule

// File: rtl/scsi_cmd_seq.sv
module scsi_cmd_seq
    import scsi_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TGT_N = 8,
    parameter int ID_W  = 4,
    parameter int BUF_N = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [7:0]            cmd_byte,
    input  logic [7:0]            tc_lo,
    input  logic [7:0]            tc_mid,
    input  logic [ID_W-1:0]       target_id,
    input  logic [TGT_N-1:0]      target_present,
    input  logic                  rst_report_dis,
    input  logic                  irq_clr,
    input  logic signed [CNT_W+1:0] tgt_len,
    input  logic                  xfer_done,
    output logic [7:0]            status,
    output logic [7:0]            intr_reason,
    output logic [2:0]            seq_step,
    output logic [4:0]            fifo_flags,
    output logic [CNT_W-1:0]      tc_cur,
    output logic                  dma_mode,
    output logic                  cmd_pending,
    output logic                  irq,
    output logic                  tgt_cmd_req,
    output logic [ID_W-1:0]       tgt_cmd_sel,
    output logic [$clog2(BUF_N):0] tgt_cmd_len,
    output logic                  xfer_req,
    output logic [CNT_W:0]        xfer_len,
    output logic                  resp_req
);
    localparam int REM_W = CNT_W + 2;
    localparam int IDX_W = $clog2(TGT_N);
    localparam int LEN_W = $clog2(BUF_N) + 1;

    typedef struct packed {
        logic [6:0]              stat;
        logic [7:0]              intr;
        logic [2:0]              step;
        logic [4:0]              flags;
        logic [CNT_W-1:0]        tc;
        logic                    dma;
        logic                    pend;
        logic                    irq;
        logic signed [REM_W-1:0] rem;
        logic                    xreq;
        logic [CNT_W:0]          xlen;
        logic                    rreq;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic             dma_sel;
    seq_op_e          op;
    logic [CNT_W-1:0] count_now;
    logic [CNT_W:0]   burst_len;
    logic [LEN_W-1:0] cmd_len;
    logic             tgt_ok;
    logic             dispatch;

    scsi_seq_decode u_decode (
        .cmd_byte (cmd_byte),
        .dma_sel  (dma_sel),
        .op       (op)
    );

    // the count reload of a DMA command is visible to the same command
    assign count_now = dma_sel ? {tc_mid, tc_lo} : st_q.tc;

    scsi_seq_len #(
        .CNT_W (CNT_W),
        .BUF_N (BUF_N),
        .REM_W (REM_W),
        .LEN_W (LEN_W)
    ) u_len (
        .count_raw (count_now),
        .remain    (st_q.rem),
        .burst_len (burst_len),
        .cmd_len   (cmd_len)
    );

    assign tgt_ok   = (target_id < ID_W'(TGT_N)) && target_present[target_id[IDX_W-1:0]];
    assign dispatch = cmd_valid && (((op == OP_SEL) && tgt_ok) || ((op == OP_XFER) && st_q.pend));

    always_comb begin
        st_d      = st_q;
        st_d.xreq = 1'b0;
        st_d.rreq = 1'b0;
        if (irq_clr) st_d.irq = 1'b0;

        if (xfer_done) begin
            st_d.stat  = st_q.stat | ST_TC;
            st_d.intr  = IR_SVC;
            st_d.step  = '0;
            st_d.flags = '0;
            st_d.tc    = '0;
            st_d.irq   = 1'b1;
            if (st_q.rem > 0) st_d.rem = st_q.rem - $signed({1'b0, st_q.xlen});
            else              st_d.rem = st_q.rem + $signed({1'b0, st_q.xlen});
        end

        if (cmd_valid) begin
            st_d.dma = dma_sel;
            if (dma_sel) st_d.tc = {tc_mid, tc_lo};
            case (op)
                OP_FLUSH: begin
                    st_d.intr  = IR_FUNC;
                    st_d.step  = '0;
                    st_d.flags = '0;
                end
                OP_CHIPRST: st_d = '0;
                OP_BUSRST: begin
                    st_d.intr = IR_BRST;
                    if (!rst_report_dis) st_d.irq = 1'b1;
                end
                OP_SEL, OP_SELSTOP: begin
                    if (!tgt_ok) begin
                        st_d.stat = '0;
                        st_d.intr = IR_DISC;
                        st_d.step = '0;
                        st_d.irq  = 1'b1;
                    end else if (op == OP_SELSTOP) begin
                        st_d.pend = 1'b1;
                        st_d.stat = ST_TC | ST_CMDP;
                        st_d.intr = IR_SVC | IR_FUNC;
                        st_d.step = STEP_CMD;
                        st_d.irq  = 1'b1;
                    end
                end
                OP_XFER: begin
                    if (st_q.pend) begin
                        st_d.pend = 1'b0;
                    end else if (dma_sel) begin
                        st_d.stat = st_d.stat & ~ST_TC;
                        if (burst_len != '0) begin
                            st_d.xreq = 1'b1;
                            st_d.xlen = burst_len;
                        end
                    end
                end
                OP_STATUS, OP_MSGOK: begin
                    st_d.rreq = 1'b1;
                    st_d.irq  = 1'b1;
                    if (dma_sel) begin
                        st_d.stat = ST_TC | ST_STSP;
                        st_d.intr = IR_SVC | IR_FUNC;
                        st_d.step = STEP_CMD;
                    end else begin
                        st_d.flags = 5'd2;
                    end
                    if (op == OP_MSGOK) begin
                        st_d.intr = IR_DISC;
                        st_d.step = '0;
                    end
                end
                default: ;
            endcase

            if (dispatch) begin
                st_d.rem = tgt_len;
                if (tgt_len != 0) st_d.stat = (tgt_len > 0) ? (ST_TC | ST_DIN) : ST_TC;
                st_d.intr = IR_SVC | IR_FUNC;
                st_d.step = STEP_CMD;
                st_d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status      = {st_q.irq, st_q.stat};
    assign intr_reason = st_q.intr;
    assign seq_step    = st_q.step;
    assign fifo_flags  = st_q.flags;
    assign tc_cur      = st_q.tc;
    assign dma_mode    = st_q.dma;
    assign cmd_pending = st_q.pend;
    assign irq         = st_q.irq;
    assign tgt_cmd_req = dispatch;
    assign tgt_cmd_sel = target_id;
    assign tgt_cmd_len = cmd_len;
    assign xfer_req    = st_q.xreq;
    assign xfer_len    = st_q.xlen;
    assign resp_req    = st_q.rreq;

    // R9, R14: the interrupt only rises because of a command or a burst end
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_valid || xfer_done));

    a_r14_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !cmd_valid && !xfer_done) |=> !irq);

    a_r8_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (xfer_len != '0 && xfer_len <= (CNT_W+1)'(1 << CNT_W)));

    a_r7_pend_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_pending) |-> $past(cmd_valid && op == OP_SELSTOP));

    a_r6_cmd_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_cmd_req |-> (tgt_cmd_len != '0 && tgt_cmd_len <= LEN_W'(BUF_N)));

    a_r6_step_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_step == 3'd0) || (seq_step == STEP_CMD));
endmodule

// File: tb/scsi_cmd_seq_bench.sv
module scsi_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic [7:0]  tc_lo = '0;
    logic [7:0]  tc_mid = '0;
    logic [3:0]  target_id = '0;
    logic [7:0]  target_present = '0;
    logic        rst_report_dis = 1'b0;
    logic        irq_clr = 1'b0;
    logic signed [17:0] tgt_len = '0;
    logic        xfer_done = 1'b0;
    logic [7:0]  status, intr_reason;
    logic [2:0]  seq_step;
    logic [4:0]  fifo_flags;
    logic [15:0] tc_cur;
    logic        dma_mode, cmd_pending, irq, tgt_cmd_req, xfer_req, resp_req;
    logic [3:0]  tgt_cmd_sel;
    logic [5:0]  tgt_cmd_len;
    logic [16:0] xfer_len;

    int n_chk = 0;
    int n_bad = 0;
    logic       req_seen;
    logic [5:0] len_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_cmd_seq u_scsi_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .tc_lo(tc_lo), .tc_mid(tc_mid), .target_id(target_id),
        .target_present(target_present), .rst_report_dis(rst_report_dis),
        .irq_clr(irq_clr), .tgt_len(tgt_len), .xfer_done(xfer_done),
        .status(status), .intr_reason(intr_reason), .seq_step(seq_step),
        .fifo_flags(fifo_flags), .tc_cur(tc_cur), .dma_mode(dma_mode),
        .cmd_pending(cmd_pending), .irq(irq), .tgt_cmd_req(tgt_cmd_req),
        .tgt_cmd_sel(tgt_cmd_sel), .tgt_cmd_len(tgt_cmd_len),
        .xfer_req(xfer_req), .xfer_len(xfer_len), .resp_req(resp_req)
    );

    typedef struct packed {
        logic [7:0]         cmd;
        logic               rpt;
        logic [3:0]         tid;
        logic [7:0]         pres;
        logic signed [17:0] tlen;
        logic [7:0]         e_stat;
        logic [7:0]         e_intr;
        logic [2:0]         e_step;
        logic [7:0]         req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 1'b0, 4'd0, 8'hFF, 18'sd0,  8'h00, 8'h08, 3'd0, 8'd3},   // R3 flush
        '{8'h03, 1'b0, 4'd0, 8'hFF, 18'sd0,  8'h80, 8'h80, 3'd0, 8'd4},   // R4 reported
        '{8'h03, 1'b1, 4'd0, 8'hFF, 18'sd0,  8'h00, 8'h80, 3'd0, 8'd4},   // R4 suppressed
        '{8'h42, 1'b0, 4'd9, 8'hFF, 18'sd5,  8'h80, 8'h20, 3'd0, 8'd5},   // R5 id out of range
        '{8'h43, 1'b0, 4'd2, 8'hFB, 18'sd5,  8'h80, 8'h20, 3'd0, 8'd5},   // R5 absent
        '{8'h42, 1'b0, 4'd2, 8'h04, 18'sd5,  8'h91, 8'h18, 3'd4, 8'd6},   // R6 data in
        '{8'h42, 1'b0, 4'd7, 8'h80, -18'sd3, 8'h90, 8'h18, 3'd4, 8'd6},   // R6 data out
        '{8'h42, 1'b0, 4'd0, 8'h01, 18'sd0,  8'h80, 8'h18, 3'd4, 8'd6},   // R6 no data
        '{8'h43, 1'b0, 4'd1, 8'h02, 18'sd0,  8'h92, 8'h18, 3'd4, 8'd7},   // R7 stop
        '{8'h91, 1'b0, 4'd0, 8'h00, 18'sd0,  8'h93, 8'h18, 3'd4, 8'd10},  // R10 dma
        '{8'h11, 1'b0, 4'd0, 8'h00, 18'sd0,  8'h80, 8'h00, 3'd0, 8'd10},  // R10 fifo
        '{8'h12, 1'b0, 4'd0, 8'h00, 18'sd0,  8'h80, 8'h20, 3'd0, 8'd11},  // R11
        '{8'h1A, 1'b0, 4'd0, 8'hFF, 18'sd0,  8'h00, 8'h00, 3'd0, 8'd13},  // R13 set atn
        '{8'h44, 1'b0, 4'd0, 8'hFF, 18'sd0,  8'h00, 8'h00, 3'd0, 8'd13},  // R13 enable sel
        '{8'h7E, 1'b0, 4'd0, 8'hFF, 18'sd0,  8'h00, 8'h00, 3'd0, 8'd13}   // R13 unknown
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        #1;
        req_seen = tgt_cmd_req;
        len_seen = tgt_cmd_len;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        hw_reset();
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 intr", intr_reason, 8'h00);
        chk("R1 step", seq_step, 3'd0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 dma/pend", {dma_mode, cmd_pending}, 2'b00);
        chk("R1 tc", tc_cur, 16'h0);

        for (int i = 0; i < NV; i++) begin
            hw_reset();
            rst_report_dis = VECS[i].rpt;
            target_id      = VECS[i].tid;
            target_present = VECS[i].pres;
            tgt_len        = VECS[i].tlen;
            issue(VECS[i].cmd);
            chk($sformatf("R%0d status v%0d", VECS[i].req, i), status, VECS[i].e_stat);
            chk($sformatf("R%0d intr v%0d", VECS[i].req, i), intr_reason, VECS[i].e_intr);
            chk($sformatf("R%0d step v%0d", VECS[i].req, i), seq_step, VECS[i].e_step);
        end
        rst_report_dis = 1'b0;

        // R5 / R6 request line
        hw_reset();
        target_id = 4'd9; target_present = 8'hFF;
        issue(8'h42);
        chk("R5 no request", req_seen, 1'b0);
        target_id = 4'd3; target_present = 8'h08; tc_lo = 8'd12; tc_mid = 8'd0; tgt_len = 18'sd1;
        issue(8'hC2);
        chk("R6 request", req_seen, 1'b1);
        chk("R6 cmd len", len_seen, 6'd12);

        // R2 DMA flag and count reload
        hw_reset();
        tc_lo = 8'h34; tc_mid = 8'h12;
        issue(8'h80);
        chk("R2 dma set", dma_mode, 1'b1);
        chk("R2 tc load", tc_cur, 16'h1234);
        tc_lo = 8'h00; tc_mid = 8'h00;
        issue(8'h00);
        chk("R2 dma clear", dma_mode, 1'b0);
        chk("R2 tc kept", tc_cur, 16'h1234);
        chk("R13 nop status", status, 8'h00);

        // R7 stopped selection then transfer
        target_id = 4'd3; target_present = 8'h08; tgt_len = 18'sd7;
        issue(8'hC3);
        chk("R7 no request", req_seen, 1'b0);
        chk("R7 pending", cmd_pending, 1'b1);
        pulse_clr();
        chk("R14 irq cleared", irq, 1'b0);
        issue(8'h90);
        chk("R7 dispatch", req_seen, 1'b1);
        chk("R7 len cap", len_seen, 6'd32);
        chk("R7 pending clear", cmd_pending, 1'b0);
        chk("R7 status", status, 8'h91);
        chk("R7 no burst", xfer_req, 1'b0);

        // R8 / R9 data-in bursts
        pulse_clr();
        tc_lo = 8'd4;
        issue(8'h90);
        chk("R8 burst req", xfer_req, 1'b1);
        chk("R8 burst len by count", xfer_len, 17'd4);
        chk("R8 tc cleared bit", status, 8'h01);
        pulse_done();
        chk("R9 status", status, 8'h91);
        chk("R9 intr", intr_reason, 8'h10);
        chk("R9 step", seq_step, 3'd0);
        chk("R9 tc", tc_cur, 16'h0);
        pulse_clr();
        tc_lo = 8'h80;
        issue(8'h90);
        chk("R8 burst len by remainder", xfer_len, 17'd3);
        pulse_done();
        pulse_clr();
        tc_lo = 8'd5;
        issue(8'h90);
        chk("R8 nothing outstanding", xfer_req, 1'b0);
        chk("R8 status", status, 8'h01);

        // R10 / R3 fifo flags
        issue(8'h11);
        chk("R10 fifo flags", fifo_flags, 5'd2);
        chk("R10 resp pulse", resp_req, 1'b1);
        issue(8'h01);
        chk("R3 flags cleared", fifo_flags, 5'd0);

        // R8 data-out bursts
        tgt_len = -18'sd10;
        issue(8'h42);
        chk("R6 data out status", status, 8'h90);
        pulse_clr();
        tc_lo = 8'd6;
        issue(8'h90);
        chk("R8 out len", xfer_len, 17'd6);
        pulse_done();
        tc_lo = 8'h20;
        issue(8'h90);
        chk("R8 out remainder", xfer_len, 17'd4);

        // R12 chip reset mid-sequence
        issue(8'h02);
        chk("R12 status", status, 8'h00);
        chk("R12 irq", irq, 1'b0);
        chk("R12 dma/tc", {dma_mode, tc_cur}, 17'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule